// File: doc/BRIEF.md
# DMA Request/Acknowledge Card Handshake

This block sits on an expansion card and connects a local word source (for transfers from the card into host memory) or a local word sink (for transfers from host memory into the card) to a host DMA engine. The engine uses a request line, an active-low acknowledge and a terminal-count flag. The block raises the request while the local side can take part in one more word. It treats each low pulse of the acknowledge as one word moved, and completes that word when the acknowledge returns high. The request may stay high across words when the local side can cover more than the word in flight. This gives continuous bursts without a full four-phase return to idle.

Software arms the block with a local start pulse. The host flags the final word by holding terminal count high during its acknowledge. The request then drops at once, and the block stays silent until it is armed again. The card's data bus buffer is enabled only while the acknowledge is low. Its direction follows the transfer direction input. All bus inputs are sampled on the card clock.

Top module: `dma_hs_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dma_req`, `src_pop`, `snk_push` and `buf_en` are all 0. After reset the block is disarmed.
- R2: With `to_card`=0, armed and no word in flight, `dma_req` equals the inverse of `src_empty`. The sink flags have no effect in this direction. No request is made before a `start` pulse.
- R3: With `to_card`=1, armed and no word in flight, `dma_req` equals the inverse of `snk_full`. The source flags have no effect in this direction.
- R4: While a word is in flight, the request stays high only if one more word can follow. A word is in flight from the acknowledge going low until its completion is visible to the local side. Reading requires `src_aempty`=0 (at least two words). Writing requires `snk_afull`=0 (room for at least two words).
- R5: With `to_card`=0, `src_pop` pulses high for exactly one cycle. This is the first cycle in which `dack_n` is high after a clock that sampled it low. It never pulses when `to_card`=1.
- R6: With `to_card`=1, `snk_push` is high for one cycle, the cycle after `src_pop` would have pulsed. `snk_data` then equals `bus_din` as sampled at the last clock edge where `dack_n` was low.
- R7: `buf_en` is high exactly while `dack_n` is low. `buf_to_card` equals `to_card`.
- R8: If `tc` is 1 at a clock edge where `dack_n` is low, `dma_req` is 0 from the next cycle onward. The current word still completes through R5/R6.
- R9: A `start` pulse arms the block and clears a seen terminal count, so requests resume under R2/R3.
- R10: `bus_dout` always presents `src_data`, the head word of the local source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm pulse for a new transfer |
| to_card | input | 1 | Direction: 1 = host memory to card, 0 = card to host memory |
| dma_req | output | 1 | DMA request to the host |
| dack_n | input | 1 | Active-low acknowledge from the host |
| tc | input | 1 | Terminal count, high during the final word |
| bus_din | input | DW | Data from the host bus |
| bus_dout | output | DW | Data to the host bus |
| buf_en | output | 1 | Data bus buffer enable |
| buf_to_card | output | 1 | Data bus buffer direction, 1 = toward card |
| src_empty | input | 1 | Local source has no word |
| src_aempty | input | 1 | Local source has at most one word |
| src_data | input | DW | Head word of local source |
| src_pop | output | 1 | Consume the head word of the source |
| snk_full | input | 1 | Local sink has no room |
| snk_afull | input | 1 | Local sink has room for at most one word |
| snk_push | output | 1 | Write `snk_data` into the sink |
| snk_data | output | DW | Word captured from the host bus |

## Verification
The assertions assume that the host keeps `to_card` steady for a whole transfer, and that `dack_n` stays high for at least two clocks between words. They also assume that the local FIFO flags update within one cycle of a pop or push. The bench changes direction only while the bus is idle and spaces every acknowledge by several clocks. It drives the FIFO flags directly as constants for each step, so each flag combination is deliberate rather than produced by a FIFO model.

// File: rtl/dma_hs_port.sv
module dma_hs_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          to_card,
  output logic          dma_req,
  input  logic          dack_n,
  input  logic          tc,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          buf_en,
  output logic          buf_to_card,
  input  logic          src_empty,
  input  logic          src_aempty,
  input  logic [DW-1:0] src_data,
  output logic          src_pop,
  input  logic          snk_full,
  input  logic          snk_afull,
  output logic          snk_push,
  output logic [DW-1:0] snk_data
);

  logic          armed, tc_seen, dack_q, push_q;
  logic [DW-1:0] stage_q, data_q;
  logic          ack_done, busy, room;

  assign ack_done = dack_n & ~dack_q;
  assign busy     = ~dack_n | ~dack_q | push_q;

  always_comb begin
    if (to_card) room = busy ? ~snk_afull  : ~snk_full;
    else         room = busy ? ~src_aempty : ~src_empty;
  end

  assign dma_req     = armed & ~tc_seen & room;
  assign src_pop     = ack_done & ~to_card;
  assign snk_push    = push_q;
  assign snk_data    = data_q;
  assign bus_dout    = src_data;
  assign buf_en      = ~dack_n;
  assign buf_to_card = to_card;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      tc_seen <= 1'b0;
      dack_q  <= 1'b1;
      push_q  <= 1'b0;
      stage_q <= '0;
      data_q  <= '0;
    end else begin
      dack_q <= dack_n;
      push_q <= ack_done & to_card;
      if (!dack_n) stage_q <= bus_din;
      if (ack_done) data_q <= stage_q;
      if (start) begin
        armed   <= 1'b1;
        tc_seen <= 1'b0;
      end else begin
        if (!dack_n && tc) tc_seen <= 1'b1;
        if (ack_done && tc_seen) armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_hs_port_chk.sv
module dma_hs_port_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          to_card,
  input logic          dma_req,
  input logic          dack_n,
  input logic          tc,
  input logic [DW-1:0] bus_din,
  input logic          src_empty,
  input logic          src_pop,
  input logic          snk_full,
  input logic          snk_push,
  input logic [DW-1:0] snk_data
);

  p_no_req_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_card && src_empty) |-> !dma_req);

  p_no_req_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (to_card && snk_full) |-> !dma_req);

  p_single_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |=> !src_pop);

  p_pop_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> (!to_card && dack_n));

  p_push_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snk_push |-> (snk_data == $past(bus_din, 2) && $past(dack_n) && !$past(dack_n, 2)));

  p_tc_stops_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !dack_n) |=> !dma_req);

endmodule

bind dma_hs_port dma_hs_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .to_card(to_card), .dma_req(dma_req),
  .dack_n(dack_n), .tc(tc), .bus_din(bus_din), .src_empty(src_empty),
  .src_pop(src_pop), .snk_full(snk_full), .snk_push(snk_push),
  .snk_data(snk_data)
);

// File: tb/sim_dma_hs_port.sv
`timescale 1ns/1ps
module sim_dma_hs_port;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, to_card = 1'b0;
  logic dack_n = 1'b1, tc = 1'b0;
  logic [DW-1:0] bus_din = '0, src_data = '0;
  logic src_empty = 1'b1, src_aempty = 1'b1, snk_full = 1'b0, snk_afull = 1'b0;
  logic dma_req, buf_en, buf_to_card, src_pop, snk_push;
  logic [DW-1:0] bus_dout, snk_data;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_hs_port #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .to_card(to_card),
    .dma_req(dma_req), .dack_n(dack_n), .tc(tc), .bus_din(bus_din),
    .bus_dout(bus_dout), .buf_en(buf_en), .buf_to_card(buf_to_card),
    .src_empty(src_empty), .src_aempty(src_aempty), .src_data(src_data),
    .src_pop(src_pop), .snk_full(snk_full), .snk_afull(snk_afull),
    .snk_push(snk_push), .snk_data(snk_data)
  );

  // {to_card, src_empty, src_aempty, snk_full, snk_afull, expected dma_req}
  localparam logic [5:0] VEC [8] = '{
    6'b0_0_0_0_0_1, 6'b0_1_1_0_0_0, 6'b0_0_1_0_0_1, 6'b0_0_0_1_1_1,
    6'b1_0_0_0_0_1, 6'b1_0_0_1_1_0, 6'b1_0_0_0_1_1, 6'b1_1_1_0_0_1
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 req in reset", {31'd0, dma_req}, 32'd0);
    chk("R1 buf_en in reset", {31'd0, buf_en}, 32'd0);
    chk("R1 pop/push in reset", {30'd0, src_pop, snk_push}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", {31'd0, dma_req}, 32'd0);
    src_empty = 1'b0; src_aempty = 1'b0;
    idle(1); #0.5;
    chk("R2 no req before start", {31'd0, dma_req}, 32'd0);
    pulse_start();

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {to_card, src_empty, src_aempty, snk_full, snk_afull} = VEC[i][5:1];
      #0.5;
      chk(VEC[i][5] ? "R3 table" : "R2 table", {31'd0, dma_req}, {31'd0, VEC[i][0]});
    end

    // R10 / R5 / R7 / R4 read word, burst capable
    @(negedge clk);
    to_card = 1'b0; src_empty = 1'b0; src_aempty = 1'b0; snk_full = 1'b1;
    src_data = 32'hA5A5_0001;
    #0.5;
    chk("R10 bus_dout", bus_dout, 32'hA5A5_0001);
    chk("R7 buf off idle", {31'd0, buf_en}, 32'd0);
    @(negedge clk) dack_n = 1'b0;
    #0.5;
    chk("R7 buf on", {31'd0, buf_en}, 32'd1);
    chk("R7 dir read", {31'd0, buf_to_card}, 32'd0);
    chk("R4 burst req held", {31'd0, dma_req}, 32'd1);
    @(negedge clk) dack_n = 1'b1;
    #0.5;
    chk("R5 pop pulse", {31'd0, src_pop}, 32'd1);
    @(negedge clk); #0.5;
    chk("R5 pop single", {31'd0, src_pop}, 32'd0);
    idle(2);

    // R4 read with only one word left
    src_aempty = 1'b1;
    @(negedge clk) dack_n = 1'b0;
    #0.5;
    chk("R4 read last word drops req", {31'd0, dma_req}, 32'd0);
    @(negedge clk) dack_n = 1'b1;
    idle(3);

    // R6 / R7 / R4 write word
    to_card = 1'b1; snk_full = 1'b0; snk_afull = 1'b1; src_empty = 1'b1;
    #0.5;
    chk("R3 req write idle", {31'd0, dma_req}, 32'd1);
    @(negedge clk) begin dack_n = 1'b0; bus_din = 32'h1234_5678; end
    #0.5;
    chk("R7 dir write", {31'd0, buf_to_card}, 32'd1);
    chk("R4 write one slot drops req", {31'd0, dma_req}, 32'd0);
    @(negedge clk) begin dack_n = 1'b1; bus_din = 32'hDEAD_BEEF; end
    #0.5;
    chk("R5 no pop in write", {31'd0, src_pop}, 32'd0);
    @(negedge clk); #0.5;
    chk("R6 push", {31'd0, snk_push}, 32'd1);
    chk("R6 push data", snk_data, 32'h1234_5678);
    @(negedge clk); #0.5;
    chk("R6 push single", {31'd0, snk_push}, 32'd0);
    idle(2);

    // R8 / R9 terminal count on a read word
    to_card = 1'b0; src_empty = 1'b0; src_aempty = 1'b0;
    @(negedge clk) begin dack_n = 1'b0; tc = 1'b1; end
    @(negedge clk) begin dack_n = 1'b1; tc = 1'b0; end
    #0.5;
    chk("R8 req drops on tc", {31'd0, dma_req}, 32'd0);
    chk("R8 final word pops", {31'd0, src_pop}, 32'd1);
    idle(4); #0.5;
    chk("R8 req stays low", {31'd0, dma_req}, 32'd0);
    pulse_start();
    #0.5;
    chk("R9 rearm resumes req", {31'd0, dma_req}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule